// File: doc/BRIEF.md
# 64-bit ECC Check Code Generator and Single-Bit Fault Locator

This block takes one captured memory beat and does two jobs with it. From the 64 data bits, given as a high and a low 32-bit half, it computes the 8 check bits of a fixed parity-check matrix. It then compares those check bits with the stored code that came with the beat. The difference, the syndrome, tells which single bit went wrong: a data bit, a check bit, or nothing.

Results appear one clock after a capture strobe and stay there until the next strobe. They are the computed code, the syndrome, a flag and an index for a faulty data bit, a flag and an index for a faulty check bit, and the repaired data and check code. A bus-width select covers a narrow 32-bit memory. In that mode the stored code is passed through on 16 bits and no bit is located.

The syndrome is first matched against the columns of the 64 data bits, all in parallel, and the lowest-numbered matching column wins. Only when no data column matches is the lowest set syndrome bit reported as a faulty check bit. The block locates single-bit faults only.

Top module: `ecc_syndrome_locator`

## Requirements
- R1: `calc_code[k]`, for k = 0..7, is the XOR of the bits of `cap_hi` selected by the high mask k and the bits of `cap_lo` selected by the low mask k. The (high, low) mask pairs for k = 0..7 are (f00fe11e, c33c0ff7), (00ff00ff, 00fff0ff), (0f0f0f0f, 0f0fff00), (11113333, 7777000f), (22224444, 8888222f), (44448888, ffff4441), (8888ffff, 11118882), (ffff1111, 22221114). Data bit n is `cap_lo[n]` for n < 32 and `cap_hi[n-32]` for n >= 32. The column of data bit n has, as its bit k, the bit of mask k at that data position.
- R2: With `bus_narrow` = 0, `syndrome[7:0]` equals `calc_code` XOR `cap_code[7:0]`, and `syndrome[15:8]` is zero.
- R3: With `bus_narrow` = 0, if the syndrome equals the column of some data bit, then `data_err` = 1 and `data_idx` is the lowest such n, and `chk_err` = 0.
- R4: With `bus_narrow` = 0, if the syndrome is nonzero and matches no data column, then `chk_err` = 1 and `chk_idx` is the position of the lowest set syndrome bit, and `data_err` = 0.
- R5: A zero syndrome gives `data_err` = 0 and `chk_err` = 0. The repaired outputs then equal the captured data and code.
- R6: `{fixed_hi, fixed_lo}` equals `{cap_hi, cap_lo}` with data bit `data_idx` inverted when `data_err` = 1, and is unchanged otherwise.
- R7: With `bus_narrow` = 0, `fixed_code[7:0]` equals `cap_code[7:0]` with bit `chk_idx` inverted when `chk_err` = 1, and `fixed_code[15:8]` is zero.
- R8: With `bus_narrow` = 1, `syndrome` and `fixed_code` both equal `cap_code[15:0]`, both flags are 0, and the repaired data equals the captured data. `calc_code` still follows R1.
- R9: All outputs load only on a clock edge where `cap_valid` = 1. They hold their values while `cap_valid` = 0.
- R10: A synchronous reset with `rst_n` = 0 clears every output to zero.
- R11: `data_idx` is zero whenever `data_err` = 0, and `chk_idx` is zero whenever `chk_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_valid | input | 1 | Capture strobe; loads the results at this edge |
| cap_hi | input | 32 | Captured data, bits 63..32 |
| cap_lo | input | 32 | Captured data, bits 31..0 |
| cap_code | input | 16 | Stored check code; only the low 8 bits are used on a 64-bit bus |
| bus_narrow | input | 1 | 1 = 32-bit memory bus, 0 = 64-bit memory bus |
| calc_code | output | 8 | Check code computed from the captured data |
| syndrome | output | 16 | Computed code XOR stored code, or the masked stored code in narrow mode |
| data_err | output | 1 | A single data bit was located |
| data_idx | output | 6 | Index of the faulty data bit |
| chk_err | output | 1 | A single check bit was located |
| chk_idx | output | 3 | Index of the faulty check bit |
| fixed_hi | output | 32 | Repaired data, bits 63..32 |
| fixed_lo | output | 32 | Repaired data, bits 31..0 |
| fixed_code | output | 16 | Repaired check code |

## Verification
The assertions assume that `cap_valid` stays low while `rst_n` is held low. If it did not, a strobe taken during reset would be checked against outputs that the reset has just cleared. The bench keeps the strobe at zero across both reset phases. It changes the capture inputs only on the falling edge, so each input value seen by the assertions at a rising edge is the one the design loaded. The "syndrome zero means no flag" property relies on every data column being nonzero, which the fixed masks make true.

// File: rtl/ecc_loc_pkg.sv
// Package: ecc_loc_pkg
// Holds the widths and the fixed parity-check matrix of the 64-bit
// fault locator. The matrix is given as one pair of 32-bit masks per
// check bit. Assumes data bit n maps to the low half for n < 32.
package ecc_loc_pkg;

    localparam int HALF_W = 32;
    localparam int DATA_W = 2 * HALF_W;
    localparam int CHK_W  = 8;
    localparam int CAP_W  = 2 * CHK_W;
    localparam int DIDX_W = $clog2(DATA_W);
    localparam int CIDX_W = $clog2(CHK_W);

    // High-half mask of check bit k
    function automatic logic [HALF_W-1:0] mask_high(input int k);
        case (k)
            0:       return 32'hf00fe11e;
            1:       return 32'h00ff00ff;
            2:       return 32'h0f0f0f0f;
            3:       return 32'h11113333;
            4:       return 32'h22224444;
            5:       return 32'h44448888;
            6:       return 32'h8888ffff;
            default: return 32'hffff1111;
        endcase
    endfunction

    // Low-half mask of check bit k
    function automatic logic [HALF_W-1:0] mask_low(input int k);
        case (k)
            0:       return 32'hc33c0ff7;
            1:       return 32'h00fff0ff;
            2:       return 32'h0f0fff00;
            3:       return 32'h7777000f;
            4:       return 32'h8888222f;
            5:       return 32'hffff4441;
            6:       return 32'h11118882;
            default: return 32'h22221114;
        endcase
    endfunction

    // Syndrome column produced by a flip of data bit n
    function automatic logic [CHK_W-1:0] column_of(input int n);
        logic [CHK_W-1:0]  col;
        logic [HALF_W-1:0] m;
        col = '0;
        for (int k = 0; k < CHK_W; k++) begin
            m = (n < HALF_W) ? mask_low(k) : mask_high(k);
            col[k] = m[n % HALF_W];
        end
        return col;
    endfunction

endpackage

// File: rtl/ecc_check_gen.sv
// Module: ecc_check_gen
// Computes the check code of one data word from the fixed matrix.
// The logic is purely combinational: one XOR tree per check bit.
// Assumes the caller registers the result.
module ecc_check_gen
    import ecc_loc_pkg::*;
(
    input  logic [HALF_W-1:0] data_hi,
    input  logic [HALF_W-1:0] data_lo,
    output logic [CHK_W-1:0]  code
);

    // One parity tree per check bit
    for (genvar k = 0; k < CHK_W; k++) begin : g_tree
        localparam logic [HALF_W-1:0] MH = mask_high(k);
        localparam logic [HALF_W-1:0] ML = mask_low(k);
        assign code[k] = (^(data_hi & MH)) ^ (^(data_lo & ML));
    end

endmodule

// File: rtl/ecc_col_locate.sv
// Module: ecc_col_locate
// Finds the faulty bit that a syndrome points at. All 64 data columns
// are compared at once, and the lowest-numbered hit wins. With no data
// hit, the lowest set syndrome bit names a check bit. Indices are zero
// when their flag is low. Purely combinational.
module ecc_col_locate
    import ecc_loc_pkg::*;
(
    input  logic [CHK_W-1:0]  syn,
    output logic              d_hit,
    output logic [DIDX_W-1:0] d_idx,
    output logic              c_hit,
    output logic [CIDX_W-1:0] c_idx
);

    logic [DATA_W-1:0] col_hit;
    logic              any_set;
    logic [CIDX_W-1:0] low_set;

    // Parallel comparison against every data column
    for (genvar n = 0; n < DATA_W; n++) begin : g_col
        localparam logic [CHK_W-1:0] COL = column_of(n);
        assign col_hit[n] = (syn == COL);
    end

    // Priority encoder: the lowest matching data column
    always_comb begin
        d_hit = 1'b0;
        d_idx = '0;
        for (int n = DATA_W - 1; n >= 0; n--) begin
            if (col_hit[n]) begin
                d_hit = 1'b1;
                d_idx = DIDX_W'(n);
            end
        end
    end

    // Priority encoder: the lowest set syndrome bit
    always_comb begin
        any_set = 1'b0;
        low_set = '0;
        for (int k = CHK_W - 1; k >= 0; k--) begin
            if (syn[k]) begin
                any_set = 1'b1;
                low_set = CIDX_W'(k);
            end
        end
    end

    // Check-bit fault only when no data column took the syndrome
    always_comb begin
        c_hit = any_set && !d_hit;
        c_idx = c_hit ? low_set : '0;
    end

endmodule

// File: rtl/ecc_result_reg.sv
// Module: ecc_result_reg
// Builds the repaired data and code and the bus-width-dependent view of
// the syndrome, then loads every result on a capture strobe. It holds
// otherwise. A synchronous active-low reset clears the outputs. In
// narrow mode both flags are forced low and the stored code passes
// through.
module ecc_result_reg
    import ecc_loc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              narrow,
    input  logic [HALF_W-1:0] in_hi,
    input  logic [HALF_W-1:0] in_lo,
    input  logic [CAP_W-1:0]  in_code,
    input  logic [CHK_W-1:0]  in_calc,
    input  logic [CHK_W-1:0]  in_syn,
    input  logic              in_dhit,
    input  logic [DIDX_W-1:0] in_didx,
    input  logic              in_chit,
    input  logic [CIDX_W-1:0] in_cidx,
    output logic [CHK_W-1:0]  q_calc,
    output logic [CAP_W-1:0]  q_syn,
    output logic              q_dhit,
    output logic [DIDX_W-1:0] q_didx,
    output logic              q_chit,
    output logic [CIDX_W-1:0] q_cidx,
    output logic [HALF_W-1:0] q_hi,
    output logic [HALF_W-1:0] q_lo,
    output logic [CAP_W-1:0]  q_code
);

    logic              n_dhit;
    logic              n_chit;
    logic [DIDX_W-1:0] n_didx;
    logic [CIDX_W-1:0] n_cidx;
    logic [DATA_W-1:0] flip_d;
    logic [CHK_W-1:0]  flip_c;
    logic [DATA_W-1:0] n_data;
    logic [CAP_W-1:0]  n_syn;
    logic [CAP_W-1:0]  n_code;

    // Locating is allowed only on the wide bus
    always_comb begin
        n_dhit = in_dhit && !narrow;
        n_chit = in_chit && !narrow;
        n_didx = n_dhit ? in_didx : '0;
        n_cidx = n_chit ? in_cidx : '0;
    end

    // One-hot flip masks for the located bit
    always_comb begin
        flip_d = '0;
        flip_c = '0;
        if (n_dhit) flip_d[n_didx] = 1'b1;
        if (n_chit) flip_c[n_cidx] = 1'b1;
    end

    // Repaired data and width-dependent syndrome and code
    always_comb begin
        n_data = {in_hi, in_lo} ^ flip_d;
        if (narrow) begin
            n_syn  = in_code;
            n_code = in_code;
        end else begin
            n_syn  = {{(CAP_W-CHK_W){1'b0}}, in_syn};
            n_code = {{(CAP_W-CHK_W){1'b0}}, in_code[CHK_W-1:0] ^ flip_c};
        end
    end

    // Result registers: clear on reset, load on strobe, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_calc <= '0;
            q_syn  <= '0;
            q_dhit <= 1'b0;
            q_didx <= '0;
            q_chit <= 1'b0;
            q_cidx <= '0;
            q_hi   <= '0;
            q_lo   <= '0;
            q_code <= '0;
        end else if (load) begin
            q_calc <= in_calc;
            q_syn  <= n_syn;
            q_dhit <= n_dhit;
            q_didx <= n_didx;
            q_chit <= n_chit;
            q_cidx <= n_cidx;
            q_hi   <= n_data[DATA_W-1:HALF_W];
            q_lo   <= n_data[HALF_W-1:0];
            q_code <= n_code;
        end
    end

endmodule

// File: rtl/ecc_syndrome_locator.sv
// Module: ecc_syndrome_locator
// Top level of the 64-bit check code generator and single-bit fault
// locator. Combinational code generation and column matching feed one
// register stage, so results follow the capture strobe by one clock.
// Assumes the stored code arrives on the same cycle as the data.
module ecc_syndrome_locator
    import ecc_loc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_valid,
    input  logic [HALF_W-1:0] cap_hi,
    input  logic [HALF_W-1:0] cap_lo,
    input  logic [CAP_W-1:0]  cap_code,
    input  logic              bus_narrow,
    output logic [CHK_W-1:0]  calc_code,
    output logic [CAP_W-1:0]  syndrome,
    output logic              data_err,
    output logic [DIDX_W-1:0] data_idx,
    output logic              chk_err,
    output logic [CIDX_W-1:0] chk_idx,
    output logic [HALF_W-1:0] fixed_hi,
    output logic [HALF_W-1:0] fixed_lo,
    output logic [CAP_W-1:0]  fixed_code
);

    logic [CHK_W-1:0]  gen_code;
    logic [CHK_W-1:0]  raw_syn;
    logic              loc_dhit;
    logic [DIDX_W-1:0] loc_didx;
    logic              loc_chit;
    logic [CIDX_W-1:0] loc_cidx;

    ecc_check_gen u_gen (
        .data_hi (cap_hi),
        .data_lo (cap_lo),
        .code    (gen_code)
    );

    // Syndrome of the wide bus: computed code against stored low byte
    always_comb raw_syn = gen_code ^ cap_code[CHK_W-1:0];

    ecc_col_locate u_loc (
        .syn   (raw_syn),
        .d_hit (loc_dhit),
        .d_idx (loc_didx),
        .c_hit (loc_chit),
        .c_idx (loc_cidx)
    );

    ecc_result_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cap_valid),
        .narrow  (bus_narrow),
        .in_hi   (cap_hi),
        .in_lo   (cap_lo),
        .in_code (cap_code),
        .in_calc (gen_code),
        .in_syn  (raw_syn),
        .in_dhit (loc_dhit),
        .in_didx (loc_didx),
        .in_chit (loc_chit),
        .in_cidx (loc_cidx),
        .q_calc  (calc_code),
        .q_syn   (syndrome),
        .q_dhit  (data_err),
        .q_didx  (data_idx),
        .q_chit  (chk_err),
        .q_cidx  (chk_idx),
        .q_hi    (fixed_hi),
        .q_lo    (fixed_lo),
        .q_code  (fixed_code)
    );

endmodule

// File: rtl/ecc_syndrome_locator_chk.sv
// Module: ecc_syndrome_locator_chk
// Assertion checker for ecc_syndrome_locator, attached by bind. It
// assumes cap_valid is low while rst_n is low.
module ecc_syndrome_locator_chk
    import ecc_loc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cap_valid,
    input logic [HALF_W-1:0] cap_hi,
    input logic [HALF_W-1:0] cap_lo,
    input logic [CAP_W-1:0]  cap_code,
    input logic              bus_narrow,
    input logic [CHK_W-1:0]  calc_code,
    input logic [CAP_W-1:0]  syndrome,
    input logic              data_err,
    input logic [DIDX_W-1:0] data_idx,
    input logic              chk_err,
    input logic [CIDX_W-1:0] chk_idx,
    input logic [HALF_W-1:0] fixed_hi,
    input logic [HALF_W-1:0] fixed_lo,
    input logic [CAP_W-1:0]  fixed_code
);

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_err && chk_err)); // R3

    AST_WIDE_SYNDROME: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid && !bus_narrow |=>
        syndrome == {8'h00, calc_code ^ $past(cap_code[CHK_W-1:0])}); // R2

    AST_ZERO_SYN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (syndrome == '0) |-> !data_err && !chk_err); // R5

    AST_DATA_FLIP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> $countones({fixed_hi, fixed_lo} ^ $past({cap_hi, cap_lo}))
                      == (data_err ? 1 : 0)); // R6

    AST_CODE_FLIP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid && !bus_narrow |=>
        $countones(fixed_code[CHK_W-1:0] ^ $past(cap_code[CHK_W-1:0]))
        == (chk_err ? 1 : 0)); // R7

    AST_NARROW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid && bus_narrow |=> !data_err && !chk_err &&
        syndrome == $past(cap_code) && fixed_code == $past(cap_code)); // R8

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |=> $stable({calc_code, syndrome, data_err, data_idx, chk_err,
                                chk_idx, fixed_hi, fixed_lo, fixed_code})); // R9

    AST_IDX_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !data_err |-> data_idx == '0); // R11

    AST_IDX_ZERO_CHK: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_err |-> chk_idx == '0); // R11

endmodule

bind ecc_syndrome_locator ecc_syndrome_locator_chk u_chk (.*);

// File: tb/ecc_syndrome_locator_test.sv
// Bench: directed scenarios for ecc_syndrome_locator, each task checking
// its own results against a reference model built from the requirements.
module ecc_syndrome_locator_test;

    localparam real CLK_NS = 4.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_valid = 1'b0;
    logic [31:0] cap_hi = '0;
    logic [31:0] cap_lo = '0;
    logic [15:0] cap_code = '0;
    logic        bus_narrow = 1'b0;
    logic [7:0]  calc_code;
    logic [15:0] syndrome;
    logic        data_err;
    logic [5:0]  data_idx;
    logic        chk_err;
    logic [2:0]  chk_idx;
    logic [31:0] fixed_hi;
    logic [31:0] fixed_lo;
    logic [15:0] fixed_code;

    int n_checks = 0;
    int n_fail   = 0;

    // expected values from the model
    logic [7:0]  e_calc;
    logic [15:0] e_syn;
    logic        e_derr;
    logic [5:0]  e_didx;
    logic        e_cerr;
    logic [2:0]  e_cidx;
    logic [63:0] e_data;
    logic [15:0] e_code;

    always #(CLK_NS / 2.0) clk = ~clk;

    ecc_syndrome_locator uut (.*);

    // matrix masks as written in R1
    function automatic logic [31:0] mh(input int k);
        case (k)
            0: return 32'hf00fe11e; 1: return 32'h00ff00ff;
            2: return 32'h0f0f0f0f; 3: return 32'h11113333;
            4: return 32'h22224444; 5: return 32'h44448888;
            6: return 32'h8888ffff; default: return 32'hffff1111;
        endcase
    endfunction
    function automatic logic [31:0] ml(input int k);
        case (k)
            0: return 32'hc33c0ff7; 1: return 32'h00fff0ff;
            2: return 32'h0f0fff00; 3: return 32'h7777000f;
            4: return 32'h8888222f; 5: return 32'hffff4441;
            6: return 32'h11118882; default: return 32'h22221114;
        endcase
    endfunction

    function automatic logic [7:0] m_calc(input logic [31:0] hi, input logic [31:0] lo);
        logic [7:0] c;
        for (int k = 0; k < 8; k++) c[k] = (^(hi & mh(k))) ^ (^(lo & ml(k)));
        return c;
    endfunction

    function automatic logic [7:0] m_col(input int n);
        logic [7:0]  c;
        logic [31:0] m;
        for (int k = 0; k < 8; k++) begin
            m = (n < 32) ? ml(k) : mh(k);
            c[k] = m[n % 32];
        end
        return c;
    endfunction

    // reference model following R1..R8 and R11
    task automatic model(input logic [31:0] hi, input logic [31:0] lo,
                         input logic [15:0] code, input logic narrow);
        logic [7:0] s;
        e_calc = m_calc(hi, lo);
        s = e_calc ^ code[7:0];
        e_derr = 1'b0; e_didx = '0; e_cerr = 1'b0; e_cidx = '0;
        e_data = {hi, lo};
        if (narrow) begin
            e_syn = code; e_code = code;
        end else begin
            e_syn = {8'h00, s};
            for (int n = 0; n < 64; n++)
                if (!e_derr && s == m_col(n)) begin e_derr = 1'b1; e_didx = 6'(n); end
            if (!e_derr)
                for (int k = 0; k < 8; k++)
                    if (!e_cerr && s[k]) begin e_cerr = 1'b1; e_cidx = 3'(k); end
            if (e_derr) e_data[e_didx] = ~e_data[e_didx];
            e_code = {8'h00, code[7:0]};
            if (e_cerr) e_code[e_cidx] = ~e_code[e_cidx];
        end
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // compare all outputs with the current expected set
    task automatic check_all(input string ctx);
        check({ctx, " R1 calc_code"}, 64'(calc_code), 64'(e_calc));
        check({ctx, e_syn[15:8] != 0 ? " R8 syndrome" : " R2 syndrome"}, 64'(syndrome), 64'(e_syn));
        check({ctx, " R3 data_err"}, 64'(data_err), 64'(e_derr));
        check({ctx, e_derr ? " R3 data_idx" : " R11 data_idx"}, 64'(data_idx), 64'(e_didx));
        check({ctx, " R4 chk_err"}, 64'(chk_err), 64'(e_cerr));
        check({ctx, e_cerr ? " R4 chk_idx" : " R11 chk_idx"}, 64'(chk_idx), 64'(e_cidx));
        check({ctx, " R6 fixed data"}, {fixed_hi, fixed_lo}, e_data);
        check({ctx, " R7 fixed_code"}, 64'(fixed_code), 64'(e_code));
    endtask

    // drive one capture on the falling edge, sample one cycle later
    task automatic capture(input logic [31:0] hi, input logic [31:0] lo,
                           input logic [15:0] code, input logic narrow, input string ctx);
        @(negedge clk);
        cap_hi = hi; cap_lo = lo; cap_code = code; bus_narrow = narrow;
        cap_valid = 1'b1;
        @(negedge clk);
        cap_valid = 1'b0;
        model(hi, lo, code, narrow);
        check_all(ctx);
    endtask

    task automatic t_reset();
        check("R10 calc after reset", 64'(calc_code), 0);
        check("R10 syndrome after reset", 64'(syndrome), 0);
        check("R10 flags after reset", 64'({data_err, chk_err}), 0);
        check("R10 data after reset", {fixed_hi, fixed_lo}, 0);
        check("R10 code after reset", 64'(fixed_code), 0);
    endtask

    task automatic t_clean();
        logic [31:0] h, l;
        for (int i = 0; i < 16; i++) begin
            h = $urandom; l = $urandom;
            capture(h, l, {8'h5a, m_calc(h, l)}, 1'b0, "clean");
            check("R5 no flag on clean word", 64'({data_err, chk_err}), 0);
        end
        capture(32'h0, 32'h0, 16'h0, 1'b0, "zero");
        capture(32'hffffffff, 32'hffffffff, {8'h0, m_calc('1, '1)}, 1'b0, "ones");
    endtask

    task automatic t_data_single();
        logic [31:0] h, l;
        logic [63:0] d;
        for (int n = 0; n < 64; n++) begin
            h = $urandom; l = $urandom;
            d = {h, l} ^ (64'd1 << n);
            capture(d[63:32], d[31:0], {8'h00, m_calc(h, l)}, 1'b0, "data1");
            check("R6 data repaired to original", {fixed_hi, fixed_lo}, {h, l});
        end
    endtask

    task automatic t_check_single();
        logic [31:0] h, l;
        for (int k = 0; k < 8; k++) begin
            h = $urandom; l = $urandom;
            capture(h, l, {8'h00, m_calc(h, l) ^ (8'd1 << k)}, 1'b0, "chk1");
        end
    endtask

    task automatic t_multi();
        logic [31:0] h, l;
        for (int i = 0; i < 24; i++) begin
            h = $urandom; l = $urandom;
            capture(h, l, 16'($urandom), 1'b0, "multi");
        end
    endtask

    task automatic t_narrow();
        logic [31:0] h, l;
        for (int i = 0; i < 8; i++) begin
            h = $urandom; l = $urandom;
            capture(h ^ 32'h1, l, 16'($urandom), 1'b1, "narrow");
            check("R8 no locate in narrow mode", 64'({data_err, chk_err}), 0);
        end
    endtask

    task automatic t_hold();
        logic [31:0] h, l;
        h = $urandom; l = $urandom;
        capture(h, l ^ 32'h10, {8'h00, m_calc(h, l)}, 1'b0, "hold-load");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            cap_hi = $urandom; cap_lo = $urandom; cap_code = 16'($urandom);
            bus_narrow = i[0];
        end
        @(negedge clk);
        check_all("R9 hold");
    endtask

    task automatic t_reset_mid();
        logic [31:0] h, l;
        h = $urandom; l = $urandom;
        capture(h ^ 32'h8000, l, {8'h00, m_calc(h, l)}, 1'b0, "pre-reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
    endtask

    initial begin : watchdog
        #(CLK_NS * 100000.0);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_data_single();
        t_check_single();
        t_multi();
        t_narrow();
        t_hold();
        t_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule